// File: doc/BRIEF.md
# Audio Transmit Queue Controller

This block is the storage stage of a serial audio output path. A host-side write port deposits audio words into a four-slot queue. A serializer-side read strobe removes one word per channel slot. A single run control from the host starts and stops the queue. The queue is sequenced by an explicit controller. Its current state is published as a 3-bit status code, so software or a neighbouring block can watch the queue move through idle, clearing, filling, draining and flushing.

Raising the run control clears every slot, one per cycle, and then opens the queue for traffic. Dropping the run control does not discard data. The controller enters a flush phase, refuses new words, and keeps serving reads until the last stored word has gone out. Only then does it return to idle.

Each time the last stored word is read, an empty interrupt pulses. This happens whether the queue is in normal operation or flushing. The serializer reads slots even when its output is muted or carries one channel only, so the interrupt fires in those cases as well. Writing to a full queue is refused and latches an overflow flag. Reading an empty queue returns zero and changes nothing.

Top module: `audio_txq_ctrl`

## Requirements
- R1: After a synchronous reset, the status is 0 (STOP), the level is 0, and the read data, empty interrupt and overflow flag are all 0.
- R2: In STOP with run high, the status becomes 1 (INIT) on the next clock. INIT then lasts exactly DEPTH (4) cycles, clearing one slot per cycle, and the status becomes 4 (EMPTY).
- R3: In normal operation the status follows the level: 2 (FULL) at level DEPTH, 4 (EMPTY) at level 0, and 3 (LACK) otherwise. Codes 6 and 7 never appear, and the level never exceeds DEPTH.
- R4: Words leave in the order they were written. A read strobe accepted at one clock edge shows its word on the read data output after that edge, for one cycle. The output is zero in every cycle that follows no accepted read.
- R5: A write while the level is DEPTH is dropped and the level is unchanged. Such a write sets a sticky overflow flag, which is cleared only by reset or by the STOP-to-INIT transition.
- R6: A read at level 0 returns zero on the read data output and leaves the level and the status unchanged.
- R7: A write and a read at the same clock edge, with a level strictly between 0 and DEPTH, leave the level unchanged and return the oldest word.
- R8: Dropping run in EMPTY, LACK or FULL moves the status to 5 (FLUSH) on the next clock. In FLUSH, writes are ignored and reads continue. The status goes to 0 (STOP) on the edge where the level reaches 0, or on the first FLUSH cycle if the level is already 0.
- R9: The empty interrupt is high for exactly one cycle after the edge at which a read takes the level from 1 to 0. This applies in normal operation and in FLUSH.
- R10: In STOP and INIT, writes and reads have no effect: the level stays 0 and the read data output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run control: high starts the queue, low requests a drain and stop |
| wr_en_i | input | 1 | Write strobe from the host side |
| wr_data_i | input | DATA_W | Audio word to store |
| rd_en_i | input | 1 | Read strobe from the serializer, one per channel slot |
| rd_data_o | output | DATA_W | Word taken by the previous accepted read, zero otherwise |
| state_o | output | 3 | Status code: 0 STOP, 1 INIT, 2 FULL, 3 LACK, 4 EMPTY, 5 FLUSH |
| level_o | output | clog2(DEPTH+1) | Number of stored words |
| empty_irq_o | output | 1 | One-cycle pulse when the last stored word is read |
| ovf_o | output | 1 | Sticky flag: a write arrived while the queue was full |

## Verification
The assertions check on every cycle that the status code agrees with the level and that the reserved codes never appear. They also check that a start request in STOP always enters INIT, that FLUSH only ever leaves to STOP, that a refused write leaves the level at DEPTH with the overflow flag set, and that the empty interrupt never lasts two cycles. Some behaviours need the bench's scripted scenarios. These are the first-in-first-out order of the data, the exact length of INIT, the data returned when a read and a write meet at the same edge, and the drain of stored words during FLUSH. The bench sweeps every fill depth from zero to full and compares each word against values computed arithmetically.

// File: rtl/audio_txq_pkg.sv
`timescale 1ns/1ps
package audio_txq_pkg;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_INIT  = 3'd1,
    ST_FULL  = 3'd2,
    ST_LACK  = 3'd3,
    ST_EMPTY = 3'd4,
    ST_FLUSH = 3'd5
  } txq_state_e;

endpackage

// File: rtl/txq_store.sv
`timescale 1ns/1ps
// Simple dual-port storage with a registered read, shaped for block RAM inference.
module txq_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/txq_ptrs.sv
`timescale 1ns/1ps
// Write/read pointers and the occupancy count.
module txq_ptrs #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [AW-1:0]    wr_ptr_o,
  output logic [AW-1:0]    rd_ptr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [AW-1:0] wr_inc, rd_inc;

  generate
    if (POW2) begin : g_wrap_free
      assign wr_inc = wr_ptr_o + 1'b1;
      assign rd_inc = rd_ptr_o + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_inc = (wr_ptr_o == AW'(DEPTH - 1)) ? '0 : wr_ptr_o + 1'b1;
      assign rd_inc = (rd_ptr_o == AW'(DEPTH - 1)) ? '0 : rd_ptr_o + 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_nxt_o = cnt_o + CNT_W'(push_i) - CNT_W'(pop_i);
    if (clr_i) cnt_nxt_o = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_ptr_o <= '0;
      rd_ptr_o <= '0;
      cnt_o    <= '0;
    end else begin
      if (push_i) wr_ptr_o <= wr_inc;
      if (pop_i)  rd_ptr_o <= rd_inc;
      cnt_o <= cnt_nxt_o;
    end
  end

endmodule

// File: rtl/txq_seq.sv
`timescale 1ns/1ps
// State sequencer: decides which strobes are accepted and tracks the status.
module txq_seq
  import audio_txq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             wr_req_i,
  input  logic             rd_req_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output txq_state_e       state_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             clr_o,
  output logic             init_we_o,
  output logic [AW-1:0]    init_addr_o,
  output logic             ovf_o,
  output logic             irq_o
);

  txq_state_e st_nxt;
  logic       active, flushing, at_full, at_zero;

  function automatic txq_state_e level_code(input logic [CNT_W-1:0] c);
    if (c == CNT_W'(DEPTH)) return ST_FULL;
    if (c == '0)            return ST_EMPTY;
    return ST_LACK;
  endfunction

  always_comb begin
    active    = (state_o == ST_FULL) || (state_o == ST_LACK) || (state_o == ST_EMPTY);
    flushing  = (state_o == ST_FLUSH);
    at_full   = (cnt_i == CNT_W'(DEPTH));
    at_zero   = (cnt_i == '0);
    push_o    = active && wr_req_i && !at_full;
    pop_o     = (active || flushing) && rd_req_i && !at_zero;
    clr_o     = (state_o == ST_STOP) && run_i;
    init_we_o = (state_o == ST_INIT);
  end

  always_comb begin
    st_nxt = state_o;
    unique case (state_o)
      ST_STOP:  if (run_i) st_nxt = ST_INIT;
      ST_INIT:  if (init_addr_o == AW'(DEPTH - 1)) st_nxt = ST_EMPTY;
      ST_FULL, ST_LACK, ST_EMPTY:
                st_nxt = run_i ? level_code(cnt_nxt_i) : ST_FLUSH;
      ST_FLUSH: if (cnt_nxt_i == '0) st_nxt = ST_STOP;
      default:  st_nxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o     <= ST_STOP;
      init_addr_o <= '0;
      ovf_o       <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      state_o     <= st_nxt;
      init_addr_o <= (state_o == ST_INIT) ? init_addr_o + 1'b1 : '0;
      if (clr_o)                           ovf_o <= 1'b0;
      else if (active && wr_req_i && at_full) ovf_o <= 1'b1;
      irq_o <= !at_zero && (cnt_nxt_i == '0) && (active || flushing);
    end
  end

endmodule

// File: rtl/audio_txq_ctrl.sv
`timescale 1ns/1ps
module audio_txq_ctrl
  import audio_txq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run_i,
  input  logic                         wr_en_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         rd_en_i,
  output logic [DATA_W-1:0]            rd_data_o,
  output logic [2:0]                   state_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         empty_irq_o,
  output logic                         ovf_o
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  txq_state_e        st;
  logic              push, pop, clr, init_we;
  logic [AW-1:0]     init_addr, wr_ptr, rd_ptr, waddr;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [DATA_W-1:0] wdata, ram_q;
  logic              pop_q;

  txq_seq #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .wr_req_i   (wr_en_i),
    .rd_req_i   (rd_en_i),
    .cnt_i      (cnt),
    .cnt_nxt_i  (cnt_nxt),
    .state_o    (st),
    .push_o     (push),
    .pop_o      (pop),
    .clr_o      (clr),
    .init_we_o  (init_we),
    .init_addr_o(init_addr),
    .ovf_o      (ovf_o),
    .irq_o      (empty_irq_o)
  );

  txq_ptrs #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr),
    .push_i   (push),
    .pop_i    (pop),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .cnt_o    (cnt),
    .cnt_nxt_o(cnt_nxt)
  );

  // INIT borrows the write port to zero one slot per cycle.
  assign waddr = init_we ? init_addr : wr_ptr;
  assign wdata = init_we ? '0 : wr_data_i;

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .we_i   (init_we || push),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .re_i   (pop),
    .raddr_i(rd_ptr),
    .rdata_o(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) pop_q <= 1'b0;
    else     pop_q <= pop;
  end

  assign rd_data_o = pop_q ? ram_q : '0;
  assign state_o   = st;
  assign level_o   = cnt;

endmodule

// File: rtl/audio_txq_chk.sv
`timescale 1ns/1ps
module audio_txq_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       run_i,
  input logic                       wr_en_i,
  input logic                       rd_en_i,
  input logic [DATA_W-1:0]          rd_data_o,
  input logic [2:0]                 state_o,
  input logic [$clog2(DEPTH+1)-1:0] level_o,
  input logic                       empty_irq_o,
  input logic                       ovf_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o <= 3'd5) && (level_o <= CNT_W'(DEPTH)));

  assert_full_level_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2) |-> (level_o == CNT_W'(DEPTH)));

  assert_empty_level_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) |-> (level_o == '0));

  assert_lack_level_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3) |-> (level_o != '0 && level_o < CNT_W'(DEPTH)));

  assert_start_init_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && run_i) |=> (state_o == 3'd1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 && wr_en_i && !rd_en_i) |=> (level_o == CNT_W'(DEPTH) && ovf_o));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && rd_en_i && !wr_en_i && run_i)
      |=> (rd_data_o == '0 && level_o == '0 && state_o == 3'd4));

  assert_flush_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd5) |=> (state_o == 3'd5 || state_o == 3'd0));

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    empty_irq_o |=> !empty_irq_o);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    empty_irq_o |-> (level_o == '0));

  assert_idle_level_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 || state_o == 3'd1) |-> (level_o == '0));

endmodule

bind audio_txq_ctrl audio_txq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_i      (run_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .state_o    (state_o),
  .level_o    (level_o),
  .empty_irq_o(empty_irq_o),
  .ovf_o      (ovf_o)
);

// File: tb/sim_audio_txq_ctrl.sv
`timescale 1ns/1ps
module sim_audio_txq_ctrl;

  localparam int DW = 16;
  localparam int D  = 4;
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [2:0]    state;
  logic [LW-1:0] level;
  logic          irq, ovf;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  audio_txq_ctrl #(.DATA_W(DW), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .run_i(run), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .state_o(state), .level_o(level),
    .empty_irq_o(irq), .ovf_o(ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [DW-1:0] d, input logic r);
    wr_en = w; wr_data = d; rd_en = r;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  function automatic int code_of(input int lvl);
    if (lvl == D) return 2;
    if (lvl == 0) return 4;
    return 3;
  endfunction

  function automatic logic [DW-1:0] word(input int n, input int k);
    return DW'(16'hA000 + n * 16 + k * 3 + 1);
  endfunction

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "state", state, 0);
    chk("R1", "level", level, 0);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "ovf", ovf, 0);

    // R10 strobes in STOP have no effect
    step(1'b1, 16'h1234, 1'b0);
    step(1'b0, '0, 1'b1);
    chk("R10", "stop level", level, 0);
    chk("R10", "stop rd_data", rd_data, 0);

    // R2 start: INIT for exactly D cycles
    run = 1'b1;
    for (int c = 0; c < D; c++) begin
      step(1'b1, 16'h5555, 1'b1);
      chk("R2", "init state", state, 1);
      chk("R10", "init level", level, 0);
      chk("R10", "init rd_data", rd_data, 0);
    end
    step(1'b0, '0, 1'b0);
    chk("R2", "after init", state, 4);

    // Sweep every fill depth
    for (int n = 0; n <= D; n++) begin
      for (int k = 0; k < n; k++) begin
        step(1'b1, word(n, k), 1'b0);
        chk("R3", "fill level", level, k + 1);
        chk("R3", "fill state", state, code_of(k + 1));
      end
      if (n == D) begin
        chk("R5", "ovf before", ovf, 0);
        step(1'b1, 16'hDEAD, 1'b0);
        chk("R5", "ovf level", level, D);
        chk("R5", "ovf flag", ovf, 1);
        chk("R5", "ovf state", state, 2);
      end
      for (int k = 0; k < n; k++) begin
        step(1'b0, '0, 1'b1);
        chk("R4", "order", rd_data, word(n, k));
        chk("R3", "drain level", level, n - k - 1);
        chk("R3", "drain state", state, code_of(n - k - 1));
        chk("R9", "irq on drain", irq, (k == n - 1) ? 1 : 0);
      end
      step(1'b0, '0, 1'b0);
      chk("R9", "irq cleared", irq, 0);
      chk("R4", "idle rd_data", rd_data, 0);
      step(1'b0, '0, 1'b1);
      chk("R6", "empty rd_data", rd_data, 0);
      chk("R6", "empty level", level, 0);
      chk("R6", "empty state", state, 4);
      chk("R9", "no irq on empty read", irq, 0);
    end
    chk("R5", "ovf sticky", ovf, 1);

    // R7 simultaneous read and write in LACK
    step(1'b1, 16'h0B01, 1'b0);
    step(1'b1, 16'h0B02, 1'b0);
    step(1'b1, 16'h0B03, 1'b0);
    step(1'b1, 16'h0B04, 1'b1);
    chk("R7", "rw level", level, 3);
    chk("R7", "rw data", rd_data, 16'h0B01);
    chk("R7", "rw state", state, 3);

    // R8 flush drains remaining words
    run = 1'b0;
    step(1'b0, '0, 1'b0);
    chk("R8", "enter flush", state, 5);
    chk("R8", "flush level", level, 3);
    step(1'b1, 16'hBAD0, 1'b0);
    chk("R8", "flush write ignored", level, 3);
    run = 1'b1;
    step(1'b0, '0, 1'b1);
    chk("R8", "flush read 1", rd_data, 16'h0B02);
    chk("R8", "flush stays", state, 5);
    step(1'b0, '0, 1'b1);
    chk("R8", "flush read 2", rd_data, 16'h0B03);
    run = 1'b0;
    step(1'b0, '0, 1'b1);
    chk("R8", "flush read 3", rd_data, 16'h0B04);
    chk("R8", "flush to stop", state, 0);
    chk("R9", "flush irq", irq, 1);
    chk("R8", "flush level end", level, 0);
    step(1'b0, '0, 1'b0);
    chk("R9", "flush irq end", irq, 0);
    chk("R8", "stay stop", state, 0);

    // R5 overflow flag cleared by restart
    run = 1'b1;
    step(1'b0, '0, 1'b0);
    chk("R2", "restart init", state, 1);
    chk("R5", "ovf cleared", ovf, 0);
    repeat (D) step(1'b0, '0, 1'b0);
    chk("R2", "restart empty", state, 4);

    // R8 stop while already empty
    run = 1'b0;
    step(1'b0, '0, 1'b0);
    chk("R8", "empty to flush", state, 5);
    step(1'b0, '0, 1'b0);
    chk("R8", "flush to stop at zero", state, 0);
    chk("R9", "no irq at zero", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule